// File: doc/BRIEF.md
# System tick countdown timer

This block is a periodic down-counter for generating a regular system heartbeat. Software programs a reload value, clears the counter and sets the enable bit; from then on, every cycle in which the tick-enable input is high moves the counter one step toward zero. When an enabled tick finds the counter at zero, the counter reloads and the block can raise a one-cycle interrupt request.

Three 32-bit registers are reachable over a simple single-cycle register bus: a control and status word, a reload value and the live counter value. Read data and the error flag are combinational in the access cycle. Register state changes at the clock edge that closes the cycle.

Writes that set reserved bits are refused and flagged on the error output. Reading the control word clears its sticky count flag. Any write to the counter register forces the counter to zero.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, the control word, the reload value and the counter all read as zero, and `irq` is low.
- R2: Byte offsets decode as follows: 0x010 is the control word, 0x014 the reload value and 0x018 the counter. The control word reads as enable in bit 0, interrupt enable in bit 1, a spare stored bit in bit 2 and the count flag in bit 16. The reload and counter registers read with bits 31:24 zero. An unmapped offset reads as zero.
- R3: A control write that sets any bit outside bits 0-2 and 16 (mask 0xFFFEFFF8) raises `bus_err` and changes nothing. A control write without error stores bits 2:0 and clears the count flag.
- R4: A reload write that sets any of bits 31:24 raises `bus_err` and leaves the reload value unchanged. Otherwise bits 23:0 are stored.
- R5: A write of any value to the counter register sets the counter to zero and clears the count flag. This write takes priority over a tick in the same cycle.
- R6: With enable (bit 0) set and `tick_en` high, a nonzero counter decrements by one. With `tick_en` low or enable clear, the counter holds.
- R7: An enabled tick that finds the counter at zero loads the reload value.
- R8: When a reload happens with interrupt enable (bit 1) set, `irq` is high for exactly the next cycle. No pulse occurs when bit 1 is clear.
- R9: The count flag is set by the tick that takes the counter from 1 to 0. It stays set until a control read, which returns the old value and then clears it. A flag set in the same cycle as a control read survives that read.
- R10: `bus_err` is high only in write cycles, and never for reads or for writes to unmapped offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Count step qualifier |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Write refused because reserved bits were set |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench aims at the cycle where a control read and the 1-to-0 tick coincide. A design that let the clear win would lose that event, and the second read would show no flag. It writes the counter register in a cycle that also carries a tick: a design that let the tick win would leave a reload value or a decremented count instead of zero. It sends reserved-bit writes to both checked registers and looks for stored corruption. It times the interrupt pulse to a single cycle with interrupt enable both on and off, so a stuck, late or ungated request shows up.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam logic [11:0] OFF_CTRL = 12'h010;
  localparam logic [11:0] OFF_LOAD = 12'h014;
  localparam logic [11:0] OFF_CUR  = 12'h018;
  localparam int          FLAG_POS = 16;
  localparam logic [31:0] CTRL_LEGAL = 32'h0001_0007;

  // assemble the visible control word
  function automatic logic [31:0] ctrl_word(input logic [2:0] lo, input logic flag);
    return 32'(lo) | (32'(flag) << FLAG_POS);
  endfunction

  // true when a control write touches reserved bits
  function automatic logic ctrl_bad(input logic [31:0] v);
    return |(v & ~CTRL_LEGAL);
  endfunction
endpackage

// File: rtl/st_decode.sv
module st_decode
  import systick_pkg::*;
#(
  parameter int AW    = 12,
  parameter int CNT_W = 24
) (
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic          hit_ctrl,
  output logic          hit_load,
  output logic          hit_cur,
  output logic          wr_ctrl_ok,
  output logic          wr_load_ok,
  output logic          wr_cur,
  output logic          rd_ctrl,
  output logic          err
);
  logic load_bad;
  logic wcyc;

  assign hit_ctrl = (addr == AW'(OFF_CTRL));
  assign hit_load = (addr == AW'(OFF_LOAD));
  assign hit_cur  = (addr == AW'(OFF_CUR));
  assign wcyc     = sel & wr;
  assign load_bad = |(wdata >> CNT_W);

  assign wr_ctrl_ok = wcyc & hit_ctrl & ~ctrl_bad(wdata);
  assign wr_load_ok = wcyc & hit_load & ~load_bad;
  assign wr_cur     = wcyc & hit_cur;
  assign rd_ctrl    = sel & ~wr & hit_ctrl;
  assign err        = wcyc & ((hit_ctrl & ctrl_bad(wdata)) | (hit_load & load_bad));
endmodule

// File: rtl/st_count.sv
module st_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cur,
  output logic             wrap_evt,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - ONE;
  endfunction

  logic active;
  assign active   = run & ~clr;
  assign wrap_evt = active & (cur == '0);
  assign zero_evt = active & (cur == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (clr)    cur <= '0;
    else if (run)    cur <= step(cur, reload);
  end

  // R6
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && cur != '0) |=> cur == $past(cur) - ONE);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cur));
  // R7
  wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cur == $past(reload));
  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cur == '0);
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import systick_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  output logic          irq
);
  logic             hit_ctrl, hit_load, hit_cur;
  logic             wr_ctrl_ok, wr_load_ok, wr_cur, rd_ctrl;
  logic [2:0]       ctrl_lo;
  logic             flag;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cur;
  logic             wrap_evt, zero_evt;
  logic             flag_clr;

  st_decode #(.AW(AW), .CNT_W(CNT_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .hit_ctrl(hit_ctrl), .hit_load(hit_load), .hit_cur(hit_cur),
    .wr_ctrl_ok(wr_ctrl_ok), .wr_load_ok(wr_load_ok), .wr_cur(wr_cur),
    .rd_ctrl(rd_ctrl), .err(bus_err)
  );

  st_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_lo[0] & tick_en), .clr(wr_cur),
    .reload(reload_q), .cur(cur), .wrap_evt(wrap_evt), .zero_evt(zero_evt)
  );

  assign flag_clr = rd_ctrl | wr_ctrl_ok | wr_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_lo  <= '0;
      flag     <= 1'b0;
      reload_q <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl_ok) ctrl_lo  <= bus_wdata[2:0];
      if (wr_load_ok) reload_q <= bus_wdata[CNT_W-1:0];
      if (zero_evt)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      irq <= wrap_evt & ctrl_lo[1];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = ctrl_word(ctrl_lo, flag);
    else if (hit_load) bus_rdata = 32'(reload_q);
    else if (hit_cur)  bus_rdata = 32'(cur);
  end

  // R3
  ctrl_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && hit_ctrl) |=> $stable(ctrl_lo));
  // R4
  load_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && hit_load) |=> $stable(reload_q));
  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wrap_evt && ctrl_lo[1]));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> flag);
  // R10
  err_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_sel && bus_wr));
endmodule

// File: tb/sys_tick_timer_tb.sv
module sys_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, irq;
  int          checks = 0, errors = 0;

  localparam logic [11:0] A_CTRL = 12'h010, A_LOAD = 12'h014, A_CUR = 12'h018;

  always #10 clk = ~clk;

  sys_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic cyc(input logic s, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic t,
                     output logic [31:0] rd, output logic er);
    sel = s; wr = w; addr = a; wdata = d; tick_en = t;
    #1; rd = rdata; er = err;
    @(negedge clk);
    sel = 0; wr = 0; tick_en = 0;
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d, output logic er);
    logic [31:0] x;
    cyc(1, 1, a, d, 0, x, er);
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] rd);
    logic e;
    cyc(1, 0, a, 32'hFFFF_FFFF, 0, rd, e);
  endtask

  task automatic ticks(input int n);
    logic [31:0] x; logic e;
    for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, 1, x, e);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 0);
    rreg(A_CTRL, v); check("R1 ctrl", v, 0);
    rreg(A_LOAD, v); check("R1 reload", v, 0);
    rreg(A_CUR, v);  check("R1 counter", v, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] v; logic e;
    wreg(A_LOAD, 32'h0000_0005, e); check("R4 good err", {31'b0, e}, 0);
    wreg(A_LOAD, 32'h0100_0009, e); check("R4 bad err", {31'b0, e}, 1);
    rreg(A_LOAD, v); check("R4 reload kept", v, 5);
    wreg(A_CTRL, 32'h0000_0008, e); check("R3 bad err", {31'b0, e}, 1);
    wreg(A_CTRL, 32'h8000_0001, e); check("R3 bad err hi", {31'b0, e}, 1);
    rreg(A_CTRL, v); check("R3 ctrl kept", v, 0);
    wreg(A_CTRL, 32'h0001_0007, e); check("R3 flag bit legal", {31'b0, e}, 0);
    rreg(A_CTRL, v); check("R3 low bits stored", v, 7);
    wreg(A_CTRL, 0, e);
    cyc(1, 0, A_CTRL, 32'hFFFF_FFFF, 0, v, e); check("R10 read no err", {31'b0, e}, 0);
    wreg(12'h01C, 32'hFFFF_FFFF, e); check("R10 unmapped write", {31'b0, e}, 0);
    rreg(12'h01C, v); check("R2 unmapped read", v, 0);
  endtask

  task automatic t_count;
    logic [31:0] v; logic e;
    wreg(A_LOAD, 3, e); wreg(A_CUR, 0, e); wreg(A_CTRL, 3, e);
    ticks(1); check("R8 irq pulse", {31'b0, irq}, 1);
    rreg(A_CUR, v); check("R7 reload loaded", v, 3);
    check("R8 irq one cycle", {31'b0, irq}, 0);
    ticks(1); rreg(A_CUR, v); check("R6 decrement", v, 2);
    for (int i = 0; i < 3; i++) @(negedge clk);
    rreg(A_CUR, v); check("R6 hold without tick", v, 2);
    ticks(2); rreg(A_CUR, v); check("R6 reach zero", v, 0);
    rreg(A_CTRL, v); check("R9 flag set", v, 32'h0001_0003);
    rreg(A_CTRL, v); check("R9 cleared by read", v, 32'h0000_0003);
  endtask

  task automatic t_irq_off;
    logic [31:0] v; logic e;
    wreg(A_CTRL, 1, e); wreg(A_CUR, 0, e); wreg(A_LOAD, 2, e);
    ticks(1); check("R8 no irq when disabled", {31'b0, irq}, 0);
    rreg(A_CUR, v); check("R7 reload no irq", v, 2);
    wreg(A_CTRL, 0, e); ticks(3);
    rreg(A_CUR, v); check("R6 hold when disabled", v, 2);
  endtask

  task automatic t_cur_write;
    logic [31:0] v; logic e;
    wreg(A_LOAD, 4, e); wreg(A_CTRL, 1, e); wreg(A_CUR, 0, e);
    ticks(5); rreg(A_CTRL, v); check("R9 flag after 1->0", v, 32'h0001_0001);
    ticks(4); rreg(A_CUR, v); check("R6 count to 1", v, 1);
    ticks(1); wreg(A_CUR, 32'hDEAD_BEEF, e); check("R5 no err", {31'b0, e}, 0);
    rreg(A_CTRL, v); check("R5 flag cleared", v, 1);
    ticks(1); cyc(1, 1, A_CUR, 32'h1234, 1, v, e);
    rreg(A_CUR, v); check("R5 write beats tick", v, 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v; logic e;
    ticks(4); rreg(A_CUR, v); check("R6 setup at 1", v, 1);
    cyc(1, 0, A_CTRL, 0, 1, v, e); check("R9 read returns old", v, 1);
    rreg(A_CTRL, v); check("R9 set wins over read", v, 32'h0001_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_count();
    t_irq_off();
    t_cur_write();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule